// File: doc/BRIEF.md
# Register command queue executor

This block is a small command engine for timing-critical register updates, such as reprogramming a display pipeline during blanking. Software first writes a list of 64-bit instructions into a local instruction store, then pulses a start input. The engine fetches and runs the list on its own. It emits single-cycle transactions on a simple register write bus, and it can stall on hardware event flags that external pulse inputs set.

Each instruction word carries its opcode in bits [63:56], argument A in bits [55:32] and argument B in bits [31:0]. The engine handles five instructions. A write puts 32-bit data on the bus. A mask instruction arms a bit mask for the write that follows it. A wait-for-event holds execution until an event flag reaches a chosen value, then may rewrite that flag. An end-of-command instruction can raise an interrupt pulse. A jump moves the program counter by a signed instruction offset. A jump whose target lies outside the store ends the run and returns the engine to idle.

Top module: `cq_exec`

## Requirements
- R1: After reset, busy_o, irq_o, err_o and wr_valid_o are low and every event flag is clear.
- R2: Opcode field [63:56] decodes as write = 0x04, mask = 0x02, wait-for-event = 0x20, end-of-command = 0x40 and jump = 0x10. Argument A is [55:32] and argument B is [31:0].
- R3: A write raises wr_valid_o for one cycle. wr_data_o is argument B. wr_addr_o is {REGION_BASE + A[23:16], A[15:1], 1'b0}, with REGION_BASE = 0x1400 by default. When A[0] = 0, wr_mask_o is all ones.
- R4: A mask instruction stores the inverse of argument B. The next write with A[0] = 1 presents that stored value on wr_mask_o, and the target merges old and new data bit by bit under it. Every write returns the stored mask to all ones.
- R5: A wait-for-event uses A[6:0] as the event index. In argument B, bit 15 enables waiting, bits 11:0 are the wait value, bit 31 enables the update and bits 27:16 are the update value. The engine holds, with no bus traffic, while the flag differs from (wait value != 0). After that it writes (update value != 0) into the flag if the update is enabled.
- R6: A wait-for-event with only the update enabled and an update value of 0 clears the flag without stalling.
- R7: An event pulse on evt_set_i in the same cycle that a wait-for-event clears that flag wins, so the flag stays set.
- R8: An end-of-command instruction with B[0] = 1 gives a one-cycle irq_o pulse. With B[0] = 0 it gives none.
- R9: A jump adds signed argument B to the current instruction index. A target below 0 or at DEPTH or above ends the run with busy_o low and err_o low.
- R10: An unknown opcode stops the run and sets err_o. err_o stays set until the next start, and no further writes occur.
- R11: While busy_o is high, start_i is ignored and instruction-store writes through load_we_i are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_we_i | input | 1 | Instruction store write enable |
| load_addr_i | input | AW | Instruction store write index |
| load_data_i | input | 64 | Instruction word |
| start_i | input | 1 | Start execution at index 0 |
| evt_set_i | input | NUM_EVT | Event set pulses, one per flag |
| busy_o | output | 1 | Engine is running a list |
| irq_o | output | 1 | End-of-command interrupt pulse |
| err_o | output | 1 | Run stopped on an unknown opcode |
| wr_valid_o | output | 1 | Register write strobe |
| wr_addr_o | output | 32 | Register write address |
| wr_data_o | output | 32 | Register write data |
| wr_mask_o | output | 32 | Per-bit write mask for the target |

## Verification
The assertions rely on three conditions: reset is applied before the first start, event pulses use indices below NUM_EVT, and the instruction store is not rewritten during a run. The block enforces the last condition by dropping loads while busy. The stimulus loads every list while the engine is idle. The one exception is a deliberate load issued during a stall, and that load is ignored. Each list ends with an out-of-range jump. Event pulses are driven on falling edges and last exactly one or two cycles, so the set-versus-clear collision happens in a known cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam logic [7:0] OP_WRITE = 8'h04;
  localparam logic [7:0] OP_MASK  = 8'h02;
  localparam logic [7:0] OP_WFE   = 8'h20;
  localparam logic [7:0] OP_EOC   = 8'h40;
  localparam logic [7:0] OP_JUMP  = 8'h10;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] arg_a;
    logic [31:0] arg_b;
  } cq_instr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} cq_state_e;
endpackage

// File: rtl/cq_imem.sv
module cq_imem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [63:0]   wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [63:0]   rd_data_o
);
  logic [63:0] mem_q [DEPTH];
  logic [63:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read word is held while no fetch is issued (stall keeps its instruction)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/cq_evt_flags.sv
module cq_evt_flags #(
  parameter int NUM_EVT = 128,
  parameter int IW      = $clog2(NUM_EVT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic               upd_en_i,
  input  logic [IW-1:0]      upd_idx_i,
  input  logic               upd_val_i,
  input  logic [IW-1:0]      rd_idx_i,
  output logic               rd_o
);
  logic [NUM_EVT-1:0] flags_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       flags_q[g] <= 1'b0;
      else if (set_i[g])                                 flags_q[g] <= 1'b1;
      else if (upd_en_i && (upd_idx_i == IW'(g)))        flags_q[g] <= upd_val_i;
    end
  end

  assign rd_o = flags_q[rd_idx_i];

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R7

  AST_UPDATE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !set_i[upd_idx_i]) |=> (flags_q[$past(upd_idx_i)] == $past(upd_val_i))); // R6
endmodule

// File: rtl/cq_core.sv
module cq_core
  import cq_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          AW          = $clog2(DEPTH),
  parameter int          EVT_IW      = 7,
  parameter logic [15:0] REGION_BASE = 16'h1400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              err_o,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [63:0]       rd_data_i,
  input  logic              flag_i,
  output logic [EVT_IW-1:0] flag_idx_o,
  output logic              upd_en_o,
  output logic              upd_val_o,
  output logic              wr_valid_o,
  output logic [31:0]       wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [31:0]       wr_mask_o
);
  cq_state_e        state_q;
  logic [AW-1:0]    pc_q;
  logic [31:0]      mask_q;
  logic             err_q, irq_q;
  logic             wr_valid_q;
  logic [31:0]      wr_addr_q, wr_data_q, wr_mask_q;

  cq_instr_t        ins;
  logic             wait_en, wait_tgt, upd_en, upd_tgt, stall;
  logic [AW:0]      pc_inc;
  logic             inc_ok;
  logic signed [32:0] tgt_s;
  logic             jmp_ok;
  logic [15:0]      region;
  logic             in_exec;

  always_comb begin
    ins      = cq_instr_t'(rd_data_i);
    in_exec  = (state_q == ST_EXEC);
    wait_en  = ins.arg_b[15];
    wait_tgt = |ins.arg_b[11:0];
    upd_en   = ins.arg_b[31];
    upd_tgt  = |ins.arg_b[27:16];
    stall    = wait_en && (flag_i != wait_tgt);
    pc_inc   = {1'b0, pc_q} + (AW+1)'(1);
    inc_ok   = (32'(pc_inc) < 32'(DEPTH));
    tgt_s    = $signed({{(33-AW){1'b0}}, pc_q}) + $signed({ins.arg_b[31], ins.arg_b});
    jmp_ok   = !tgt_s[32] && (tgt_s[31:0] < 32'(DEPTH));
    region   = REGION_BASE + {8'h00, ins.arg_a[23:16]};
  end

  assign flag_idx_o = ins.arg_a[EVT_IW-1:0];
  assign upd_en_o   = in_exec && (ins.op == OP_WFE) && !stall && upd_en;
  assign upd_val_o  = upd_tgt;
  assign rd_en_o    = (state_q == ST_FETCH);
  assign rd_addr_o  = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pc_q       <= '0;
      mask_q     <= '1;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_mask_q  <= '1;
    end else begin
      wr_valid_q <= 1'b0;
      irq_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pc_q    <= '0;
            err_q   <= 1'b0;
            mask_q  <= '1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_EXEC;
        ST_EXEC: begin
          unique case (ins.op)
            OP_WRITE: begin
              wr_valid_q <= 1'b1;
              wr_addr_q  <= {region, ins.arg_a[15:1], 1'b0};
              wr_data_q  <= ins.arg_b;
              wr_mask_q  <= ins.arg_a[0] ? mask_q : '1;
              mask_q     <= '1;
              pc_q       <= pc_inc[AW-1:0];
              state_q    <= inc_ok ? ST_FETCH : ST_IDLE;
            end
            OP_MASK: begin
              mask_q  <= ~ins.arg_b;
              pc_q    <= pc_inc[AW-1:0];
              state_q <= inc_ok ? ST_FETCH : ST_IDLE;
            end
            OP_WFE: begin
              if (!stall) begin
                pc_q    <= pc_inc[AW-1:0];
                state_q <= inc_ok ? ST_FETCH : ST_IDLE;
              end
            end
            OP_EOC: begin
              irq_q   <= ins.arg_b[0];
              pc_q    <= pc_inc[AW-1:0];
              state_q <= inc_ok ? ST_FETCH : ST_IDLE;
            end
            OP_JUMP: begin
              if (jmp_ok) begin
                pc_q    <= tgt_s[AW-1:0];
                state_q <= ST_FETCH;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign irq_o      = irq_q;
  assign err_o      = err_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign wr_mask_o  = wr_mask_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8

  AST_MASK_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (mask_q == '1)); // R4

  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R10

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && (ins.op == OP_WFE) && stall) |=> (in_exec && $stable(pc_q) && !wr_valid_o)); // R5

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && (ins.op == OP_WFE) && stall && start_i) |=> $stable(pc_q)); // R11
endmodule

// File: rtl/cq_exec.sv
module cq_exec #(
  parameter int          DEPTH       = 64,
  parameter int          NUM_EVT     = 128,
  parameter logic [15:0] REGION_BASE = 16'h1400,
  localparam int         AW          = $clog2(DEPTH),
  localparam int         EVT_IW      = $clog2(NUM_EVT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_we_i,
  input  logic [AW-1:0]      load_addr_i,
  input  logic [63:0]        load_data_i,
  input  logic               start_i,
  input  logic [NUM_EVT-1:0] evt_set_i,
  output logic               busy_o,
  output logic               irq_o,
  output logic               err_o,
  output logic               wr_valid_o,
  output logic [31:0]        wr_addr_o,
  output logic [31:0]        wr_data_o,
  output logic [31:0]        wr_mask_o
);
  logic              busy;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [63:0]       rd_data;
  logic              flag;
  logic [EVT_IW-1:0] flag_idx;
  logic              upd_en, upd_val;

  cq_imem #(.DEPTH(DEPTH), .AW(AW)) i_imem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (load_we_i && !busy),
    .wr_addr_i (load_addr_i),
    .wr_data_i (load_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  cq_evt_flags #(.NUM_EVT(NUM_EVT), .IW(EVT_IW)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_set_i),
    .upd_en_i  (upd_en),
    .upd_idx_i (flag_idx),
    .upd_val_i (upd_val),
    .rd_idx_i  (flag_idx),
    .rd_o      (flag)
  );

  cq_core #(.DEPTH(DEPTH), .AW(AW), .EVT_IW(EVT_IW), .REGION_BASE(REGION_BASE)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy),
    .irq_o      (irq_o),
    .err_o      (err_o),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .flag_i     (flag),
    .flag_idx_o (flag_idx),
    .upd_en_o   (upd_en),
    .upd_val_o  (upd_val),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_mask_o  (wr_mask_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/test_cq_exec.sv
`timescale 1ns/1ps
module test_cq_exec;
  localparam int DEPTH = 64;
  localparam int NEVT  = 128;
  localparam int AW    = $clog2(DEPTH);

  localparam logic [7:0]  O_WR = 8'h04, O_MSK = 8'h02, O_WFE = 8'h20, O_EOC = 8'h40, O_JMP = 8'h10;
  localparam logic [31:0] B_WAIT_CLR = 32'h8000_8001;
  localparam logic [31:0] B_WAIT     = 32'h0000_8001;
  localparam logic [31:0] B_CLR      = 32'h8000_0000;
  localparam logic [31:0] B_END      = 32'd256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [63:0] load_data = '0;
  logic start = 1'b0;
  logic [NEVT-1:0] evt = '0;
  logic busy, irq, err, wr_valid;
  logic [31:0] wr_addr, wr_data, wr_mask;

  always #2.5 clk = ~clk;

  cq_exec i_cq_exec (
    .clk_i(clk), .rst_ni(rst_n), .load_we_i(load_we), .load_addr_i(load_addr),
    .load_data_i(load_data), .start_i(start), .evt_set_i(evt), .busy_o(busy),
    .irq_o(irq), .err_o(err), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_mask_o(wr_mask)
  );

  int total = 0, bad = 0, cyc = 0;
  int log_n = 0, irq_n = 0;
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  logic [31:0] log_m [16];

  always @(negedge clk) begin
    if (wr_valid && log_n < 16) begin
      log_a[log_n] = wr_addr; log_d[log_n] = wr_data; log_m[log_n] = wr_mask;
      log_n = log_n + 1;
    end
    if (irq) irq_n = irq_n + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog all act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ins(input logic [7:0] op, input logic [23:0] a, input logic [31:0] b);
    return {op, a, b};
  endfunction

  task automatic ld(input int adr, input logic [63:0] w);
    @(negedge clk);
    load_we = 1'b1; load_addr = AW'(adr); load_data = w;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic kick();
    log_n = 0; irq_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int k = 0; k < limit && busy; k++) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk) evt[idx] = 1'b1;
    for (int k = 0; k < len; k++) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // R2 R3 R4: single write, optionally preceded by a mask instruction
  typedef struct packed {
    logic        use_mask;
    logic [31:0] mask_b;
    logic [23:0] arg_a;
    logic [31:0] arg_b;
    logic [31:0] exp_addr;
    logic [31:0] exp_mask;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0,         24'h000010, 32'h1111_1111, 32'h1400_0010, 32'hFFFF_FFFF},
    '{1'b0, 32'h0,         24'h02FFFC, 32'hA5A5_A5A5, 32'h1402_FFFC, 32'hFFFF_FFFF},
    '{1'b1, 32'hFFFF_00FF, 24'h000101, 32'h0000_AB00, 32'h1400_0100, 32'h0000_FF00},
    '{1'b1, 32'h0000_0000, 24'h010021, 32'h1234_5678, 32'h1401_0020, 32'hFFFF_FFFF},
    '{1'b1, 32'hFFFF_FFFE, 24'h000005, 32'h0000_0001, 32'h1400_0004, 32'h0000_0001},
    '{1'b1, 32'h0F0F_0F0F, 24'h030008, 32'h0000_0055, 32'h1403_0008, 32'hFFFF_FFFF}
  };

  initial begin
    idle_n(3);
    chk(!busy && !irq && !err && !wr_valid, "R1", "outputs in reset", {28'h0, busy, irq, err, wr_valid}, 32'h0);
    rst_n = 1'b1;
    idle_n(2);
    chk(!busy && !irq && !err && !wr_valid, "R1", "outputs after reset", {28'h0, busy, irq, err, wr_valid}, 32'h0);

    // R2 R3 R4 table walk
    for (int i = 0; i < 6; i++) begin
      int a;
      a = 0;
      if (VECS[i].use_mask) begin ld(a, ins(O_MSK, 24'h0, VECS[i].mask_b)); a++; end
      ld(a, ins(O_WR, VECS[i].arg_a, VECS[i].arg_b)); a++;
      ld(a, ins(O_EOC, 24'h0, 32'h1)); a++;
      ld(a, ins(O_JMP, 24'h0, B_END));
      kick(); wait_idle(40);
      chk(!busy && log_n == 1, "R3", "write count", 32'(log_n), 32'd1);
      chk(log_a[0] == VECS[i].exp_addr, "R3", "address", log_a[0], VECS[i].exp_addr);
      chk(log_d[0] == VECS[i].arg_b, "R3", "data", log_d[0], VECS[i].arg_b);
      chk(log_m[0] == VECS[i].exp_mask, "R4", "mask", log_m[0], VECS[i].exp_mask);
    end

    // R4: mask re-arms to all ones after a write
    ld(0, ins(O_MSK, 24'h0, 32'hFFFF_FF00));
    ld(1, ins(O_WR, 24'h000041, 32'h1));
    ld(2, ins(O_WR, 24'h000045, 32'h2));
    ld(3, ins(O_JMP, 24'h0, B_END));
    kick(); wait_idle(40);
    chk(log_n == 2 && log_m[0] == 32'h0000_00FF, "R4", "first masked", log_m[0], 32'h0000_00FF);
    chk(log_m[1] == 32'hFFFF_FFFF, "R4", "mask rearmed", log_m[1], 32'hFFFF_FFFF);

    // R5 R11: wait stalls, loads and start ignored while busy, flag cleared after
    ld(0, ins(O_WFE, 24'h00001E, B_WAIT_CLR));
    ld(1, ins(O_WR, 24'h000080, 32'hCAFE_0001));
    ld(2, ins(O_EOC, 24'h0, 32'h1));
    ld(3, ins(O_JMP, 24'h0, B_END));
    for (int r = 0; r < 2; r++) begin
      kick(); idle_n(12);
      chk(busy && log_n == 0, "R5", "stalled on clear flag", 32'(log_n), 32'd0);
      if (r == 0) begin
        ld(1, ins(O_WR, 24'h000084, 32'hBAD0_BAD0));
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      pulse(30, 1);
      wait_idle(40);
      chk(!busy && log_n == 1, "R11", "one pass of writes", 32'(log_n), 32'd1);
      chk(log_d[0] == 32'hCAFE_0001, "R11", "load dropped while busy", log_d[0], 32'hCAFE_0001);
      chk(irq_n == 1, "R8", "irq count", 32'(irq_n), 32'd1);
    end

    // R5: flag already set passes without stall
    pulse(41, 1);
    ld(0, ins(O_WFE, 24'h000029, B_WAIT_CLR));
    kick(); wait_idle(30);
    chk(!busy && log_n == 1, "R5", "preset flag no stall", 32'(log_n), 32'd1);

    // R6: clear-only then wait on same flag stalls
    pulse(40, 1);
    ld(0, ins(O_WFE, 24'h000028, B_CLR));
    ld(1, ins(O_WFE, 24'h000028, B_WAIT));
    ld(2, ins(O_WR, 24'h000090, 32'h6));
    ld(3, ins(O_JMP, 24'h0, B_END));
    kick(); idle_n(12);
    chk(busy && log_n == 0, "R6", "clear removed flag", {31'h0, busy}, 32'd1);
    pulse(40, 1);
    wait_idle(30);
    chk(!busy && log_n == 1, "R6", "released", 32'(log_n), 32'd1);

    // R7: two-cycle pulse overlaps the clear cycle
    ld(0, ins(O_WFE, 24'h000032, B_WAIT_CLR));
    ld(1, ins(O_JMP, 24'h0, B_END));
    kick(); idle_n(8);
    pulse(50, 2);
    wait_idle(30);
    ld(0, ins(O_WFE, 24'h000032, B_WAIT));
    ld(1, ins(O_WR, 24'h0000A0, 32'h7));
    ld(2, ins(O_JMP, 24'h0, B_END));
    kick(); wait_idle(30);
    chk(!busy && log_n == 1, "R7", "set beat clear", 32'(log_n), 32'd1);

    // R8: irq only when bit0 set
    ld(0, ins(O_EOC, 24'h0, 32'h0));
    ld(1, ins(O_EOC, 24'h0, 32'h1));
    ld(2, ins(O_EOC, 24'h0, 32'h3));
    ld(3, ins(O_EOC, 24'h0, 32'h2));
    ld(4, ins(O_JMP, 24'h0, B_END));
    kick(); wait_idle(40);
    chk(irq_n == 2, "R8", "irq cycles", 32'(irq_n), 32'd2);

    // R9: forward, backward and out-of-range jumps
    ld(0, ins(O_JMP, 24'h0, 32'd3));
    ld(1, ins(O_WR, 24'h0000B0, 32'hAAAA));
    ld(2, ins(O_JMP, 24'h0, B_END));
    ld(3, ins(O_WR, 24'h0000B4, 32'hBBBB));
    ld(4, ins(O_JMP, 24'h0, 32'hFFFF_FFFD));
    kick(); wait_idle(60);
    chk(!busy && !err && log_n == 2, "R9", "jump write count", 32'(log_n), 32'd2);
    chk(log_d[0] == 32'hBBBB, "R9", "first after jump", log_d[0], 32'hBBBB);
    chk(log_d[1] == 32'hAAAA, "R9", "after backward jump", log_d[1], 32'hAAAA);

    // R10: unknown opcode
    ld(0, ins(O_WR, 24'h0000C0, 32'h1));
    ld(1, ins(8'h99, 24'h0, 32'h0));
    ld(2, ins(O_WR, 24'h0000C4, 32'h2));
    ld(3, ins(O_JMP, 24'h0, B_END));
    kick(); wait_idle(40);
    chk(!busy && err, "R10", "error flag", {31'h0, err}, 32'd1);
    chk(log_n == 1, "R10", "no writes after error", 32'(log_n), 32'd1);
    idle_n(5);
    chk(err, "R10", "error held", {31'h0, err}, 32'd1);
    ld(1, ins(O_JMP, 24'h0, B_END));
    kick();
    chk(!err, "R10", "error cleared on start", {31'h0, err}, 32'd0);
    wait_idle(40);
    chk(!busy && !err, "R10", "clean run", {30'h0, busy, err}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule